// File: doc/BRIEF.md
# Switch Route Table Selector

This block picks the output port for each packet header that reaches one switch of a two-tier direct network with 56 ports. Ports 0 up to the host-port count face local host interfaces. Every other port is a network link. A header that comes in on a host port is routed from the source table set. A header that comes in on a network port is routed from the transit table set. Each set has an intra-group table and an inter-group table. The intra-group table is indexed by destination drawer and chip and is used when the destination group is this switch's own group. The inter-group table has one entry per destination group, and each entry holds two candidate ports.

The routing mode is carried in the header. Direct routing can use one fixed candidate or alternate between two parallel candidates. Indirect routing sends the packet through an intermediate group. That group is chosen by round-robin or by a pseudo-random draw, or it is named by software in the header. A header flag records whether the intermediate group has already been passed. Once a header is accepted, the decision appears one cycle later. It is held until the tail flit goes by, so that the body flits of the packet follow the header on the same port.

Top module: `rt_selector`

## Requirements
- R1: After reset no route is held and `hdr_ready` is 1. Every table entry is invalid, so any lookup made before a write ends with `route_err` = 1.
- R2: A header is accepted on a clock edge where `hdr_valid` and `hdr_ready` are both 1. `route_valid` is 1 from the next cycle on. `hdr_ready` stays 0 while a route is held.
- R3: While a route is held, `route_port`, `route_err`, `route_via` and `route_via_done` do not change. On the edge where `tail_in` is 1, the route is released, so `route_valid` is 0 in the next cycle.
- R4: A header whose `hdr_src_port` is below NUM_HOST (default 8) reads the source set (`tbl_wr_set` = 0). Any other header reads the transit set (`tbl_wr_set` = 1).
- R5: When `hdr_dst_sn` equals MY_SN (default 2), the port comes from the intra entry at index {drawer, chip}, whatever the mode. If that entry is invalid, `route_err` = 1.
- R6: Mode 0 (single direct) uses candidate slot 0 of the inter entry for `hdr_dst_sn`. The same lookup is used for any indirect mode once `hdr_via_done` = 1. Mode codes 5 to 7 act as mode 0. If slot 0 is invalid, `route_err` = 1.
- R7: Mode 1 (multiple direct) alternates slots for each source port, starting with slot 0 after reset. An invalid slot is skipped. If both slots are invalid, `route_err` = 1.
- R8: Mode 2 (round-robin indirect) on a host port picks an intermediate group whose slot 0 is valid and which is neither MY_SN nor the destination. The search starts one past that source port's last pick, wrapping around, and the pointer resets to 0. The route port is slot 0 of the pick, and `route_via` carries the pick.
- R9: Mode 3 (random indirect) on a host port picks only eligible groups, using the same rule as R8. If just one group is eligible, that group is picked. If none is eligible, `route_err` = 1.
- R10: Mode 4 (software indirect) on any port, and modes 2 or 3 on a network port, with `hdr_via_done` = 0, route to slot 0 of `hdr_via_sn`, and `route_via` equals `hdr_via_sn`.
- R11: An indirect header with `hdr_via_done` = 0 and `hdr_via_sn` = MY_SN is routed on slot 0 of its destination, with `route_via_done` = 1.
- R12: A write with `tbl_wr_en` = 1 sets the entry's valid bit and port. `tbl_wr_inter` = 0 selects intra index `tbl_wr_idx`. `tbl_wr_inter` = 1 selects inter group `tbl_wr_idx`, slot `tbl_wr_slot`. An inter write with an index at or above NUM_SN is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_set | input | 1 | 0 source set, 1 transit set |
| tbl_wr_inter | input | 1 | 0 intra table, 1 inter table |
| tbl_wr_idx | input | 5 | Intra index {drawer,chip} or group number |
| tbl_wr_slot | input | 1 | Candidate slot of an inter entry |
| tbl_wr_vld | input | 1 | Valid bit written |
| tbl_wr_port | input | 6 | Port number written |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Header can be accepted |
| hdr_src_port | input | 6 | Port the header came in on |
| hdr_mode | input | 3 | Routing mode code |
| hdr_dst_sn | input | 3 | Destination group |
| hdr_dst_drawer | input | 2 | Destination drawer |
| hdr_dst_chip | input | 3 | Destination chip |
| hdr_via_sn | input | 3 | Intermediate group from header |
| hdr_via_done | input | 1 | Intermediate group already passed |
| tail_in | input | 1 | Tail flit of held packet passes |
| route_valid | output | 1 | Route decision held |
| route_port | output | 6 | Chosen output port |
| route_err | output | 1 | No valid route found |
| route_via | output | 3 | Intermediate group used (destination if none) |
| route_via_done | output | 1 | Header flag to send onward |

## Verification
A round-robin pointer that is corrupted or not updated shows up on the very next header from the same source port, as a wrong `route_via` and port. The alternation bit of multiple-direct mode shows up the same way. A table write that lands on the wrong entry or the wrong set changes the port of the first lookup that touches it, and the bench reads every programmed entry through lookups in both sets. Release and hold faults show at the ports within one cycle, either as a change while the route is held or as `hdr_ready` failing to return after the tail.

// File: rtl/rt_pkg.sv
// Shared definitions for the route selector: mode codes and the
// pseudo-random generator tap set. Assumes a 16-bit generator.
package rt_pkg;
    typedef enum logic [2:0] {
        MODE_DIRECT   = 3'd0,
        MODE_MULTI    = 3'd1,
        MODE_IND_RR   = 3'd2,
        MODE_IND_RAND = 3'd3,
        MODE_IND_SW   = 3'd4
    } rt_mode_e;

    localparam logic [15:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/rt_tables.sv
// Route table storage: two sets (source, transit), each with an intra-group
// table of single entries and an inter-group table of two candidates.
// Assumes one write port; reads are combinational for the selected set.
module rt_tables #(
    parameter int NUM_SN    = 8,
    parameter int NUM_INTRA = 32,
    parameter int PW        = 6,
    parameter int SNW       = 3,
    parameter int XW        = 5,
    parameter int IW        = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic                              wr_set,
    input  logic                              wr_inter,
    input  logic [IW-1:0]                     wr_idx,
    input  logic                              wr_slot,
    input  logic                              wr_vld,
    input  logic [PW-1:0]                     wr_port,
    input  logic                              rd_set,
    input  logic [XW-1:0]                     rd_intra_idx,
    output logic                              intra_vld,
    output logic [PW-1:0]                     intra_port,
    output logic [NUM_SN-1:0][1:0]            inter_vld,
    output logic [NUM_SN-1:0][1:0][PW-1:0]    inter_port
);
    logic [1:0][NUM_INTRA-1:0]               a_vld;
    logic [1:0][NUM_INTRA-1:0][PW-1:0]       a_port;
    logic [1:0][NUM_SN-1:0][1:0]             e_vld;
    logic [1:0][NUM_SN-1:0][1:0][PW-1:0]     e_port;

    // Valid bits: cleared by reset, set or cleared by writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_vld <= '0;
            e_vld <= '0;
        end else if (wr_en) begin
            if (!wr_inter) begin
                if (32'(wr_idx) < NUM_INTRA) a_vld[wr_set][XW'(wr_idx)] <= wr_vld;
            end else if (32'(wr_idx) < NUM_SN) begin
                e_vld[wr_set][SNW'(wr_idx)][wr_slot] <= wr_vld;
            end
        end
    end

    // Port fields: written alongside valid bits, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (!wr_inter) begin
                if (32'(wr_idx) < NUM_INTRA) a_port[wr_set][XW'(wr_idx)] <= wr_port;
            end else if (32'(wr_idx) < NUM_SN) begin
                e_port[wr_set][SNW'(wr_idx)][wr_slot] <= wr_port;
            end
        end
    end

    // Read ports for the set chosen by the header's ingress port.
    always_comb begin
        intra_vld  = a_vld[rd_set][rd_intra_idx];
        intra_port = a_port[rd_set][rd_intra_idx];
        inter_vld  = e_vld[rd_set];
        inter_port = e_port[rd_set];
    end
endmodule

// File: rtl/rt_lfsr.sv
// Free-running 16-bit Fibonacci generator (x^16+x^14+x^13+x^11+1) used
// for random intermediate-group choice. Steps every cycle.
module rt_lfsr #(
    parameter logic [15:0] SEED = rt_pkg::LFSR_SEED
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] value
);
    // Shift with feedback; reload the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) value <= SEED;
        else        value <= {value[14:0], value[15] ^ value[13] ^ value[12] ^ value[10]};
    end
endmodule

// File: rtl/rt_scan.sv
// Circular first-set search: returns the first set bit of mask at or after
// start, wrapping. Assumes start < N.
module rt_scan #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] mask,
    input  logic [W-1:0] start,
    output logic         found,
    output logic [W-1:0] idx
);
    // Walk N positions from start and keep the first hit.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            int p;
            p = int'(start) + k;
            if (p >= N) p = p - N;
            if (!found && mask[p]) begin
                found = 1'b1;
                idx   = W'(p);
            end
        end
    end
endmodule

// File: rtl/rt_selector.sv
// Route selector top: accepts one header, decides the output port in the
// accept cycle, registers it and holds it until the tail flit passes.
// Assumes one packet in flight per selector and no table write in the
// same cycle as a header that depends on it.
module rt_selector
    import rt_pkg::*;
#(
    parameter int NUM_PORTS = 56,
    parameter int NUM_HOST  = 8,
    parameter int NUM_SN    = 8,
    parameter int DRAWERS   = 4,
    parameter int CHIPS     = 8,
    parameter int MY_SN     = 2,
    parameter int PW        = $clog2(NUM_PORTS),
    parameter int SNW       = $clog2(NUM_SN),
    parameter int DW        = $clog2(DRAWERS),
    parameter int CW        = $clog2(CHIPS),
    parameter int IW        = (SNW > DW + CW) ? SNW : DW + CW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tbl_wr_en,
    input  logic           tbl_wr_set,
    input  logic           tbl_wr_inter,
    input  logic [IW-1:0]  tbl_wr_idx,
    input  logic           tbl_wr_slot,
    input  logic           tbl_wr_vld,
    input  logic [PW-1:0]  tbl_wr_port,
    input  logic           hdr_valid,
    output logic           hdr_ready,
    input  logic [PW-1:0]  hdr_src_port,
    input  logic [2:0]     hdr_mode,
    input  logic [SNW-1:0] hdr_dst_sn,
    input  logic [DW-1:0]  hdr_dst_drawer,
    input  logic [CW-1:0]  hdr_dst_chip,
    input  logic [SNW-1:0] hdr_via_sn,
    input  logic           hdr_via_done,
    input  logic           tail_in,
    output logic           route_valid,
    output logic [PW-1:0]  route_port,
    output logic           route_err,
    output logic [SNW-1:0] route_via,
    output logic           route_via_done
);
    localparam int NUM_INTRA = DRAWERS * CHIPS;
    localparam int XW        = DW + CW;
    localparam int NPTR      = 1 << PW;
    localparam logic [SNW-1:0] SELF = SNW'(MY_SN);

    logic                           is_host, accept;
    logic                           intra_vld;
    logic [PW-1:0]                  intra_port;
    logic [NUM_SN-1:0][1:0]         inter_vld;
    logic [NUM_SN-1:0][1:0][PW-1:0] inter_port;
    logic [15:0]                    lfsr;
    logic [NUM_SN-1:0]              elig;
    logic [SNW-1:0]                 scan_start, pick;
    logic                           pick_found;
    logic [SNW-1:0]                 rr_ptr [NPTR];
    logic                           alt    [NPTR];
    logic                           d_err, d_done, upd_rr, upd_alt, d_alt;
    logic [PW-1:0]                  d_port;
    logic [SNW-1:0]                 d_via;
    rt_mode_e                       mode;

    assign is_host   = 32'(hdr_src_port) < NUM_HOST;
    assign hdr_ready = !route_valid;
    assign accept    = hdr_valid && hdr_ready;
    assign mode      = (hdr_mode > 3'd4) ? MODE_DIRECT : rt_mode_e'(hdr_mode);

    rt_tables #(.NUM_SN(NUM_SN), .NUM_INTRA(NUM_INTRA), .PW(PW), .SNW(SNW),
                .XW(XW), .IW(IW)) u_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr_en), .wr_set(tbl_wr_set),
        .wr_inter(tbl_wr_inter), .wr_idx(tbl_wr_idx), .wr_slot(tbl_wr_slot),
        .wr_vld(tbl_wr_vld), .wr_port(tbl_wr_port), .rd_set(!is_host),
        .rd_intra_idx({hdr_dst_drawer, hdr_dst_chip}), .intra_vld(intra_vld),
        .intra_port(intra_port), .inter_vld(inter_vld), .inter_port(inter_port)
    );

    rt_lfsr u_lfsr (.clk(clk), .rst_n(rst_n), .value(lfsr));

    // Eligible intermediates: reachable on slot 0, not here, not the target.
    always_comb begin
        for (int i = 0; i < NUM_SN; i++)
            elig[i] = inter_vld[i][0] && (SNW'(i) != SELF) && (SNW'(i) != hdr_dst_sn);
        if (mode == MODE_IND_RR)
            scan_start = (32'(rr_ptr[hdr_src_port]) == NUM_SN - 1) ? '0 : rr_ptr[hdr_src_port] + 1'b1;
        else
            scan_start = SNW'(lfsr % 16'(NUM_SN));
    end

    rt_scan #(.N(NUM_SN), .W(SNW)) u_scan (
        .mask(elig), .start(scan_start), .found(pick_found), .idx(pick)
    );

    // Route decision for the header presented this cycle.
    always_comb begin
        d_err   = 1'b0;
        d_port  = '0;
        d_via   = hdr_dst_sn;
        d_done  = hdr_via_done;
        upd_rr  = 1'b0;
        upd_alt = 1'b0;
        d_alt   = 1'b0;
        if (hdr_dst_sn == SELF) begin
            d_port = intra_port;
            d_err  = !intra_vld;
        end else if ((mode == MODE_IND_RR || mode == MODE_IND_RAND || mode == MODE_IND_SW)
                     && !hdr_via_done) begin
            if (is_host && mode != MODE_IND_SW) begin
                d_via  = pick;
                d_port = inter_port[pick][0];
                d_err  = !pick_found;
                upd_rr = (mode == MODE_IND_RR) && pick_found;
            end else if (hdr_via_sn == SELF) begin
                d_done = 1'b1;
                d_port = inter_port[hdr_dst_sn][0];
                d_err  = !inter_vld[hdr_dst_sn][0];
            end else begin
                d_via  = hdr_via_sn;
                d_port = inter_port[hdr_via_sn][0];
                d_err  = !inter_vld[hdr_via_sn][0];
            end
        end else if (mode == MODE_MULTI) begin
            if (inter_vld[hdr_dst_sn][alt[hdr_src_port]]) begin
                d_port = inter_port[hdr_dst_sn][alt[hdr_src_port]];
                d_alt  = !alt[hdr_src_port];
            end else begin
                d_port = inter_port[hdr_dst_sn][!alt[hdr_src_port]];
                d_alt  = alt[hdr_src_port];
            end
            d_err   = !(|inter_vld[hdr_dst_sn]);
            upd_alt = !d_err;
        end else begin
            d_port = inter_port[hdr_dst_sn][0];
            d_err  = !inter_vld[hdr_dst_sn][0];
        end
    end

    // Held route: loaded on accept, dropped when the tail flit passes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_valid    <= 1'b0;
            route_port     <= '0;
            route_err      <= 1'b0;
            route_via      <= '0;
            route_via_done <= 1'b0;
        end else if (accept) begin
            route_valid    <= 1'b1;
            route_port     <= d_port;
            route_err      <= d_err;
            route_via      <= d_via;
            route_via_done <= d_done;
        end else if (route_valid && tail_in) begin
            route_valid    <= 1'b0;
        end
    end

    // Per-ingress-port round-robin pointers and multi-path alternation bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPTR; p++) begin
                rr_ptr[p] <= '0;
                alt[p]    <= 1'b0;
            end
        end else if (accept) begin
            if (upd_rr)  rr_ptr[hdr_src_port] <= pick;
            if (upd_alt) alt[hdr_src_port]    <= d_alt;
        end
    end
endmodule

// File: rtl/rt_selector_chk.sv
// Protocol checker for rt_selector, attached by bind. Watches ports only.
module rt_selector_chk
    import rt_pkg::*;
#(
    parameter int NUM_HOST = 8,
    parameter int MY_SN    = 2,
    parameter int PW       = 6,
    parameter int SNW      = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           hdr_valid,
    input logic           hdr_ready,
    input logic [PW-1:0]  hdr_src_port,
    input logic [2:0]     hdr_mode,
    input logic [SNW-1:0] hdr_dst_sn,
    input logic           hdr_via_done,
    input logic           tail_in,
    input logic           route_valid,
    input logic [PW-1:0]  route_port,
    input logic           route_err,
    input logic [SNW-1:0] route_via
);
    logic hw_ind;
    assign hw_ind = hdr_valid && hdr_ready && (32'(hdr_src_port) < NUM_HOST)
                    && (hdr_mode == 3'd2 || hdr_mode == 3'd3) && !hdr_via_done
                    && (hdr_dst_sn != SNW'(MY_SN));

    AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && hdr_ready |=> route_valid); // R2
    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        route_valid |-> !hdr_ready); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        route_valid && !tail_in |=> route_valid && $stable(route_port) && $stable(route_err)
                                   && $stable(route_via)); // R3
    AST_TAIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        route_valid && tail_in |=> !route_valid); // R3
    AST_VIA_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        hw_ind |=> route_err || (route_via != SNW'(MY_SN) && route_via != $past(hdr_dst_sn))); // R8
endmodule

bind rt_selector rt_selector_chk #(.NUM_HOST(NUM_HOST), .MY_SN(MY_SN), .PW(PW), .SNW(SNW)) u_chk (.*);

// File: tb/sim_rt_selector.sv
module sim_rt_selector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tbl_wr_en = 0, tbl_wr_set = 0, tbl_wr_inter = 0, tbl_wr_slot = 0, tbl_wr_vld = 0;
    logic [4:0] tbl_wr_idx = '0;
    logic [5:0] tbl_wr_port = '0;
    logic       hdr_valid = 0, hdr_ready, hdr_via_done = 0, tail_in = 0;
    logic [5:0] hdr_src_port = '0;
    logic [2:0] hdr_mode = '0, hdr_dst_sn = '0, hdr_dst_chip = '0, hdr_via_sn = '0;
    logic [1:0] hdr_dst_drawer = '0;
    logic       route_valid, route_err, route_via_done;
    logic [5:0] route_port;
    logic [2:0] route_via;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rt_selector u0 (.*);

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input bit set, input bit inter, input int idx, input bit slot,
                      input bit vld, input int port);
        @(negedge clk);
        tbl_wr_en = 1; tbl_wr_set = set; tbl_wr_inter = inter; tbl_wr_idx = 5'(idx);
        tbl_wr_slot = slot; tbl_wr_vld = vld; tbl_wr_port = 6'(port);
        @(negedge clk);
        tbl_wr_en = 0;
    endtask

    // Present one header, sample the held route, then pass the tail.
    task automatic send(input int src, input int mode, input int dst, input int dr,
                        input int ch, input int via, input bit vd);
        @(negedge clk);
        hdr_src_port = 6'(src); hdr_mode = 3'(mode); hdr_dst_sn = 3'(dst);
        hdr_dst_drawer = 2'(dr); hdr_dst_chip = 3'(ch); hdr_via_sn = 3'(via);
        hdr_via_done = vd; hdr_valid = 1;
        @(negedge clk);
        hdr_valid = 0;
    endtask

    task automatic release_tail();
        tail_in = 1;
        @(negedge clk);
        tail_in = 0;
    endtask

    task automatic t_reset();
        check("R1 ready after reset", hdr_ready, 1);
        check("R1 no route after reset", route_valid, 0);
        send(0, 0, 5, 0, 0, 0, 0);
        check("R1 empty table err", route_err, 1);
        check("R2 valid next cycle", route_valid, 1);
        release_tail();
    endtask

    task automatic t_program();
        wr(0, 1, 5, 0, 1, 20); wr(0, 1, 5, 1, 1, 21);
        wr(0, 1, 1, 0, 1, 30); wr(0, 1, 3, 0, 1, 31); wr(0, 1, 6, 0, 1, 33);
        wr(0, 0, 11, 0, 1, 9);
        wr(1, 1, 5, 0, 1, 40); wr(1, 0, 11, 0, 1, 12);
    endtask

    task automatic t_intra();
        send(0, 1, 2, 1, 3, 0, 0);
        check("R5 intra source port", route_port, 9); check("R5 intra ok", route_err, 0);
        release_tail();
        send(20, 2, 2, 1, 3, 0, 0);
        check("R4 transit set intra", route_port, 12);
        release_tail();
        send(0, 0, 2, 0, 0, 0, 0);
        check("R5 invalid intra err", route_err, 1);
        release_tail();
    endtask

    task automatic t_single();
        send(0, 0, 5, 0, 0, 0, 0);
        check("R6 single direct", route_port, 20); check("R6 no err", route_err, 0);
        release_tail();
        send(7, 2, 5, 0, 0, 1, 1);
        check("R6 via done direct", route_port, 20); check("R6 via echoes dst", route_via, 5);
        release_tail();
        send(0, 7, 5, 0, 0, 0, 0);
        check("R6 mode 7 as single", route_port, 20);
        release_tail();
        send(0, 0, 7, 0, 0, 0, 0);
        check("R6 invalid slot0 err", route_err, 1);
        release_tail();
        send(30, 0, 1, 0, 0, 0, 0);
        check("R4 transit set lacks group", route_err, 1);
        release_tail();
    endtask

    task automatic t_hold();
        send(0, 0, 5, 0, 0, 0, 0);
        hdr_valid = 1; hdr_dst_sn = 3'd1; hdr_mode = 3'd4; hdr_via_sn = 3'd6;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R3 port held", route_port, 20);
            check("R2 not ready while held", hdr_ready, 0);
        end
        hdr_valid = 0;
        release_tail();
        check("R3 released after tail", route_valid, 0);
        check("R2 ready after release", hdr_ready, 1);
    endtask

    task automatic t_multi();
        int exp [3] = '{20, 21, 20};
        for (int i = 0; i < 3; i++) begin
            send(1, 1, 5, 0, 0, 0, 0);
            check("R7 alternation", route_port, exp[i]);
            release_tail();
        end
        send(2, 1, 5, 0, 0, 0, 0);
        check("R7 per-port start slot0", route_port, 20);
        release_tail();
        for (int i = 0; i < 2; i++) begin
            send(3, 1, 6, 0, 0, 0, 0);
            check("R7 skip invalid slot", route_port, 33);
            release_tail();
        end
        send(3, 1, 7, 0, 0, 0, 0);
        check("R7 both invalid err", route_err, 1);
        release_tail();
    endtask

    task automatic t_rr();
        int ev [4] = '{1, 3, 6, 1};
        int ep [4] = '{30, 31, 33, 30};
        for (int i = 0; i < 4; i++) begin
            send(4, 2, 5, 0, 0, 0, 0);
            check("R8 rr via", route_via, ev[i]);
            check("R8 rr port", route_port, ep[i]);
            release_tail();
        end
        send(5, 2, 1, 0, 0, 0, 0);
        check("R8 rr skips dst and self", route_via, 3);
        release_tail();
    endtask

    task automatic t_sw();
        send(0, 4, 5, 0, 0, 6, 0);
        check("R10 sw via port", route_port, 33); check("R10 sw via", route_via, 6);
        check("R10 not done", route_via_done, 0);
        release_tail();
        send(30, 2, 7, 0, 0, 5, 0);
        check("R10 transit header via", route_port, 40);
        release_tail();
        send(30, 4, 5, 0, 0, 2, 0);
        check("R11 midpoint port", route_port, 40);
        check("R11 midpoint marks done", route_via_done, 1);
        release_tail();
    endtask

    task automatic t_rand();
        for (int i = 0; i < 6; i++) begin
            int v, p;
            send(6, 3, 5, 0, 0, 0, 0);
            v = route_via; p = route_port;
            check("R9 rand eligible", int'(v == 1 || v == 3 || v == 6), 1);
            check("R9 rand port matches", p, (v == 1) ? 30 : (v == 3) ? 31 : 33);
            release_tail();
        end
        wr(0, 1, 1, 0, 0, 0); wr(0, 1, 6, 0, 0, 0);
        for (int i = 0; i < 3; i++) begin
            send(6, 3, 5, 0, 0, 0, 0);
            check("R9 single eligible", route_via, 3);
            release_tail();
        end
        wr(0, 1, 3, 0, 0, 0);
        send(6, 3, 5, 0, 0, 0, 0);
        check("R9 none eligible err", route_err, 1);
        release_tail();
    endtask

    task automatic t_writes();
        wr(0, 1, 5, 0, 1, 22);
        wr(0, 1, 13, 0, 1, 50);
        send(0, 0, 5, 0, 0, 0, 0);
        check("R12 overwrite and out-of-range ignored", route_port, 22);
        release_tail();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset(); t_program(); t_intra(); t_single(); t_hold();
        t_multi(); t_rr(); t_sw(); t_rand(); t_writes();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule